// File: doc/BRIEF.md
# Bus Break Condition Comparator

This block observes a processor's bus cycles and raises break requests when programmed conditions are met. Each observed cycle carries an address, a program-counter value, data with an access size, a read/write level, bus-type tags (instruction fetch, cache hit, DMA) and an on-chip I/O flag. Three condition channels compare every valid cycle against their own programmed values. Each channel produces a one-cycle break pulse. A combined output is the OR of the three pulses.

Channel 1 supports every condition type, including a 16-bit pass counter that withholds the break until the combined condition has occurred a programmed number of times. Channel 2 supports only address and bus-state conditions, and is muted while a single-step indication is high. Channel 3 adds the data condition to what channel 2 has. Software programs the channels through a simple one-cycle register write port. Stopping the processor is left to the logic that consumes the break outputs.

Top module: `bus_break_cmp`

## Requirements
- R1: After a synchronous active-high reset, all break outputs are 0 and every channel's control word is cleared, so no condition is enabled.
- R2: A channel fires only on a cycle with `bus_valid` high. A channel whose control word enables none of the address, data, read/write, bus-type or I/O conditions never fires.
- R3: The address condition (control bit 0) compares `bus_addr` for equality against the channel's address register when control bit 1 is 0, and compares `bus_pc` when control bit 1 is 1.
- R4: The data condition (control bit 2) requires `bus_size` to equal the programmed size in control bits 11:10, using the encoding 0 byte, 1 word, 2 longword; code 3 never matches. Only the active byte lanes are compared against the same lanes of the data register. Lane k is `bus_data[8k+7:8k]`. A byte uses lane `bus_addr[1:0]`, a word uses lanes 1:0 or 3:2 as selected by `bus_addr[1]`, and a longword uses all four lanes.
- R5: The read/write condition (control bit 3) matches when `bus_read` equals control bit 4.
- R6: The bus-type condition (control bit 5) selects with bits 9:8. Code 0 matches any non-DMA cycle. Code 1 matches non-DMA cycles that are not instruction fetches. Code 2 matches DMA cycles or cycles without a cache hit. Code 3 never matches.
- R7: The I/O condition (control bit 6) matches only when `bus_io` is high.
- R8: All enabled conditions of a channel must hold on the same cycle for that channel to match.
- R9: On channel 1 with control bit 7 set, a 16-bit pass counter is reloaded from the count register on every write to that channel; a write to the count register reloads it with the new value. Each match decrements a nonzero counter. The break fires only on the match that takes the counter from 1 to 0. A counter of 0 never fires.
- R10: Enable bits that a channel does not support are dropped when written and have no effect. Channel 2 keeps only bits 0, 1, 3, 4, 5, 8 and 9. Channel 3 additionally keeps bits 2, 10 and 11.
- R11: While `step_mode` is high, channel 2 does not fire.
- R12: A break appears on `brk_hit` in the cycle after the bus cycle that caused it, for exactly one cycle. `brk_any` is the OR of the three `brk_hit` bits.
- R13: `cfg_sel[3:2]` selects the channel (0, 1, 2 for channels 1, 2, 3; code 3 writes nothing). `cfg_sel[1:0]` selects the register: 0 control, 1 address, 2 data, 3 count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Channel and register select |
| cfg_wdata | input | 32 | Configuration write data |
| bus_valid | input | 1 | A bus cycle is present |
| bus_addr | input | 32 | Bus address |
| bus_pc | input | 32 | Program-counter value |
| bus_data | input | 32 | Bus data |
| bus_size | input | 2 | Access size code |
| bus_read | input | 1 | 1 for read, 0 for write |
| bus_fetch | input | 1 | Instruction fetch cycle |
| bus_cache_hit | input | 1 | Cycle hit the cache |
| bus_dma | input | 1 | Cycle issued by DMA |
| bus_io | input | 1 | On-chip I/O access |
| step_mode | input | 1 | Single-step indication |
| brk_hit | output | 3 | Per-channel break pulse |
| brk_any | output | 1 | OR of the channel pulses |

## Verification
On every cycle, the assertions check several ways a channel must stay silent: after an idle cycle, with no condition enabled, on a size mismatch while the data condition is enabled, with an exhausted pass counter, and on channel 2 during single-step. Whether the correct byte lanes are compared, whether the bus-type codes decode correctly, whether the pass counter fires on exactly the Nth match, and whether unsupported enables are dropped can only be shown by the bench. It compares the outputs against its own model across directed and random sequences.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
    localparam int NUM_CH    = 3;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int CNT_W     = 16;
    localparam int LANES     = DATA_W / 8;
    localparam int CTRL_W    = 12;

    typedef enum logic [1:0] {SZ_BYTE, SZ_WORD, SZ_LONG, SZ_RSVD} size_e;
    typedef enum logic [1:0] {BT_CPU_ALL, BT_CPU_DATA, BT_MISS_DMA, BT_RSVD} bus_sel_e;

    typedef struct packed {
        size_e    dsize;
        bus_sel_e bsel;
        logic     cnt_en;
        logic     io_en;
        logic     bus_en;
        logic     rw_val;
        logic     rw_en;
        logic     data_en;
        logic     addr_pc;
        logic     addr_en;
    } ctrl_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] data;
        size_e             size;
        logic              rd;
        logic              fetch;
        logic              hit;
        logic              dma;
        logic              io;
    } bus_t;

    function automatic logic [CTRL_W-1:0] cap_mask(input int ch);
        case (ch)
            0:       return 12'hFFF;
            1:       return 12'h33B;
            default: return 12'hF3F;
        endcase
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input size_e sz, input logic [1:0] lo);
        case (sz)
            SZ_BYTE: return 4'b0001 << lo;
            SZ_WORD: return lo[1] ? 4'b1100 : 4'b0011;
            SZ_LONG: return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic bus_type_ok(input bus_sel_e sel, input logic fetch,
                                         input logic hit, input logic dma);
        case (sel)
            BT_CPU_ALL:  return !dma;
            BT_CPU_DATA: return !dma && !fetch;
            BT_MISS_DMA: return dma || !hit;
            default:     return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/bbc_data_match.sv
module bbc_data_match
    import bbc_pkg::*;
(
    input  logic [DATA_W-1:0] bus_data,
    input  size_e             bus_size,
    input  logic [1:0]        addr_lo,
    input  logic [DATA_W-1:0] ref_data,
    input  size_e             ref_size,
    output logic              match
);
    logic [LANES-1:0] lanes;
    logic [LANES-1:0] lane_ok;

    assign lanes = lane_mask(bus_size, addr_lo);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_ok[k] = !lanes[k] || (bus_data[8*k +: 8] == ref_data[8*k +: 8]);
    end

    assign match = (bus_size == ref_size) && (ref_size != SZ_RSVD) && (&lane_ok);
endmodule

// File: rtl/bbc_channel.sv
module bbc_channel
    import bbc_pkg::*;
#(
    parameter int CH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_reg,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bus_valid,
    input  bus_t              bus,
    input  logic              mute,
    output logic              hit
);
    localparam logic [CTRL_W-1:0] CAP = cap_mask(CH_IDX);

    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  cinit_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              hit_q;

    logic any_en, addr_ok, data_ok, rw_ok, bt_ok, io_ok, cond, fire;
    logic data_eq;

    bbc_data_match u_dm (
        .bus_data (bus.data),
        .bus_size (bus.size),
        .addr_lo  (bus.addr[1:0]),
        .ref_data (data_q),
        .ref_size (ctrl_q.dsize),
        .match    (data_eq)
    );

    always_comb begin
        any_en  = ctrl_q.addr_en | ctrl_q.data_en | ctrl_q.rw_en | ctrl_q.bus_en | ctrl_q.io_en;
        addr_ok = !ctrl_q.addr_en || ((ctrl_q.addr_pc ? bus.pc : bus.addr) == addr_q);
        data_ok = !ctrl_q.data_en || data_eq;
        rw_ok   = !ctrl_q.rw_en   || (bus.rd == ctrl_q.rw_val);
        bt_ok   = !ctrl_q.bus_en  || bus_type_ok(ctrl_q.bsel, bus.fetch, bus.hit, bus.dma);
        io_ok   = !ctrl_q.io_en   || bus.io;
        cond    = bus_valid && any_en && addr_ok && data_ok && rw_ok && bt_ok && io_ok;
        fire    = cond && (!ctrl_q.cnt_en || (cnt_q == CNT_W'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            cinit_q <= '0;
            cnt_q   <= '0;
            hit_q   <= 1'b0;
        end else begin
            hit_q <= fire && !mute;
            if (wr_en) begin
                case (wr_reg)
                    2'd0: ctrl_q  <= ctrl_t'(wr_data[CTRL_W-1:0] & CAP);
                    2'd1: addr_q  <= wr_data;
                    2'd2: data_q  <= wr_data;
                    default: cinit_q <= wr_data[CNT_W-1:0];
                endcase
                cnt_q <= (wr_reg == 2'd3) ? wr_data[CNT_W-1:0] : cinit_q;
            end else if (cond && ctrl_q.cnt_en && (cnt_q != '0)) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign hit = hit_q;

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |=> !hit_q);
    a_r2_no_enable_quiet: assert property (@(posedge clk) disable iff (rst)
        !any_en |=> !hit_q);
    a_r4_size_mismatch: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && ctrl_q.data_en && (bus.size != ctrl_q.dsize)) |=> !hit_q);
    a_r9_exhausted: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.cnt_en && (cnt_q == '0)) |=> !hit_q);
endmodule

// File: rtl/bus_break_cmp.sv
module bus_break_cmp
    import bbc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [3:0]          cfg_sel,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  logic                bus_valid,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [ADDR_W-1:0]   bus_pc,
    input  logic [DATA_W-1:0]   bus_data,
    input  logic [1:0]          bus_size,
    input  logic                bus_read,
    input  logic                bus_fetch,
    input  logic                bus_cache_hit,
    input  logic                bus_dma,
    input  logic                bus_io,
    input  logic                step_mode,
    output logic [NUM_CH-1:0]   brk_hit,
    output logic                brk_any
);
    bus_t bus;

    always_comb begin
        bus.addr  = bus_addr;
        bus.pc    = bus_pc;
        bus.data  = bus_data;
        bus.size  = size_e'(bus_size);
        bus.rd    = bus_read;
        bus.fetch = bus_fetch;
        bus.hit   = bus_cache_hit;
        bus.dma   = bus_dma;
        bus.io    = bus_io;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        bbc_channel #(.CH_IDX(g)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (cfg_we && (cfg_sel[3:2] == 2'(g))),
            .wr_reg    (cfg_sel[1:0]),
            .wr_data   (cfg_wdata),
            .bus_valid (bus_valid),
            .bus       (bus),
            .mute      ((g == 1) ? step_mode : 1'b0),
            .hit       (brk_hit[g])
        );
    end

    assign brk_any = |brk_hit;

    a_r11_step_mutes_ch2: assert property (@(posedge clk) disable iff (rst)
        step_mode |=> !brk_hit[1]);
endmodule

// File: tb/bus_break_cmp_bench.sv
module bus_break_cmp_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        bus_valid;
    logic [31:0] bus_addr, bus_pc, bus_data;
    logic [1:0]  bus_size;
    logic        bus_read, bus_fetch, bus_cache_hit, bus_dma, bus_io, step_mode;
    logic [2:0]  brk_hit;
    logic        brk_any;

    int vectors = 0;
    int errors  = 0;

    logic [11:0] ctrl_m  [3];
    logic [31:0] addr_m  [3];
    logic [31:0] data_m  [3];
    logic [15:0] cinit_m [3];
    logic [15:0] cnt_m   [3];
    logic [2:0]  exp_hit;

    always #10 clk = ~clk;

    bus_break_cmp u_bus_break_cmp (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_pc(bus_pc), .bus_data(bus_data),
        .bus_size(bus_size), .bus_read(bus_read), .bus_fetch(bus_fetch),
        .bus_cache_hit(bus_cache_hit), .bus_dma(bus_dma), .bus_io(bus_io),
        .step_mode(step_mode), .brk_hit(brk_hit), .brk_any(brk_any)
    );

    function automatic logic [11:0] allowed(input int ch);
        if (ch == 0) return 12'hFFF;
        if (ch == 1) return 12'h33B;
        return 12'hF3F;
    endfunction

    function automatic logic model_cond(input int ch);
        logic [11:0] c;
        logic [3:0]  m;
        logic        ok;
        c  = ctrl_m[ch];
        ok = bus_valid && (c[0] | c[2] | c[3] | c[5] | c[6]);
        if (c[0]) ok &= ((c[1] ? bus_pc : bus_addr) == addr_m[ch]);
        if (c[2]) begin
            case (bus_size)
                2'd0: m = 4'b0001 << bus_addr[1:0];
                2'd1: m = bus_addr[1] ? 4'b1100 : 4'b0011;
                2'd2: m = 4'b1111;
                default: m = 4'b0000;
            endcase
            ok &= (bus_size == c[11:10]) && (c[11:10] != 2'd3);
            for (int k = 0; k < 4; k++)
                if (m[k]) ok &= (bus_data[8*k +: 8] == data_m[ch][8*k +: 8]);
        end
        if (c[3]) ok &= (bus_read == c[4]);
        if (c[5]) begin
            case (c[9:8])
                2'd0: ok &= !bus_dma;
                2'd1: ok &= !bus_dma && !bus_fetch;
                2'd2: ok &= bus_dma || !bus_cache_hit;
                default: ok = 1'b0;
            endcase
        end
        if (c[6]) ok &= bus_io;
        return ok;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input int ch, input int rg, input logic [31:0] val);
        @(negedge clk);
        bus_valid = 1'b0;
        cfg_we    = 1'b1;
        cfg_sel   = {2'(ch), 2'(rg)};
        cfg_wdata = val;
        if (ch < 3) begin
            case (rg)
                0: ctrl_m[ch]  = val[11:0] & allowed(ch);
                1: addr_m[ch]  = val;
                2: data_m[ch]  = val;
                default: cinit_m[ch] = val[15:0];
            endcase
            cnt_m[ch] = (rg == 3) ? val[15:0] : cinit_m[ch];
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive one bus cycle at a negedge, sample one cycle later (R12 latency).
    task automatic cyc(input string tag);
        logic c;
        for (int ch = 0; ch < 3; ch++) begin
            c = model_cond(ch);
            exp_hit[ch] = 1'b0;
            if (c) begin
                if (ch == 0 && ctrl_m[0][7]) begin
                    exp_hit[ch] = (cnt_m[0] == 16'd1);
                    if (cnt_m[0] != 0) cnt_m[0] = cnt_m[0] - 16'd1;
                end else exp_hit[ch] = 1'b1;
            end
        end
        if (step_mode) exp_hit[1] = 1'b0;
        @(posedge clk);
        #2;
        check({tag, " R12 brk_hit"}, 32'(brk_hit), 32'(exp_hit));
        check({tag, " R12 brk_any"}, 32'(brk_any), 32'(|exp_hit));
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic set_bus(input logic [31:0] a, input logic [31:0] p, input logic [31:0] d,
                           input logic [1:0] sz, input logic rd);
        bus_valid = 1'b1; bus_addr = a; bus_pc = p; bus_data = d; bus_size = sz; bus_read = rd;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; bus_valid = 0;
        bus_addr = 0; bus_pc = 0; bus_data = 0; bus_size = 0; bus_read = 0;
        bus_fetch = 0; bus_cache_hit = 0; bus_dma = 0; bus_io = 0; step_mode = 0;
        for (int ch = 0; ch < 3; ch++) begin
            ctrl_m[ch] = 0; addr_m[ch] = 0; data_m[ch] = 0; cinit_m[ch] = 0; cnt_m[ch] = 0;
        end
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset brk_hit", 32'(brk_hit), 0);
        check("R1 reset brk_any", 32'(brk_any), 0);
        @(negedge clk);
        rst = 1'b0;

        // R1/R2: cleared config -> nothing fires even on a valid cycle
        set_bus(0, 0, 0, 2, 1);
        cyc("R1 R2 no enable");
        check("R2 no enable", 32'(exp_hit), 0);

        // R3: address via bus address and via PC
        wr(0, 1, 32'h1000_0040); wr(0, 0, 12'h001);
        set_bus(32'h1000_0040, 32'h0, 0, 2, 1); cyc("R3 addr");
        check("R3 bus addr hit", 32'(exp_hit[0]), 1);
        wr(0, 0, 12'h003);
        set_bus(32'h1000_0040, 32'h0, 0, 2, 1); cyc("R3 pc miss");
        check("R3 pc select miss", 32'(exp_hit[0]), 0);
        set_bus(32'h0, 32'h1000_0040, 0, 2, 1); cyc("R3 pc hit");
        check("R3 pc select hit", 32'(exp_hit[0]), 1);
        bus_valid = 0;
        set_bus(32'h0, 32'h1000_0040, 0, 2, 1); bus_valid = 0; cyc("R2 idle");
        check("R2 idle", 32'(exp_hit[0]), 0);

        // R4: byte lane 2 on channel 3, size match and mismatch
        wr(2, 2, 32'h00AB_0000); wr(2, 0, 12'h004);
        set_bus(32'h2002, 0, 32'h11AB_2233, 0, 1); cyc("R4 byte lane2");
        check("R4 byte lane hit", 32'(exp_hit[2]), 1);
        set_bus(32'h2003, 0, 32'h11AB_2233, 0, 1); cyc("R4 byte lane3");
        check("R4 wrong lane", 32'(exp_hit[2]), 0);
        set_bus(32'h2002, 0, 32'h00AB_0000, 1, 1); cyc("R4 size mismatch");
        check("R4 size mismatch", 32'(exp_hit[2]), 0);
        wr(2, 0, 12'hC04);
        set_bus(32'h2000, 0, 32'h00AB_0000, 3, 1); cyc("R4 reserved size");
        check("R4 reserved size", 32'(exp_hit[2]), 0);

        // R5, R6, R7, R8 on channel 1
        wr(0, 0, 32'h0000_0078);  // rw_en, rw_val=1(read), bus_en sel0, io_en
        set_bus(0, 0, 0, 2, 1); bus_io = 1; bus_dma = 0; cyc("R8 all hold");
        check("R8 all hold", 32'(exp_hit[0]), 1);
        set_bus(0, 0, 0, 2, 0); cyc("R5 write");
        check("R5 write mismatch", 32'(exp_hit[0]), 0);
        set_bus(0, 0, 0, 2, 1); bus_io = 0; cyc("R7 no io");
        check("R7 no io", 32'(exp_hit[0]), 0);
        wr(0, 0, 32'h0000_0220);  // bus_en, sel 2
        set_bus(0, 0, 0, 2, 1); bus_cache_hit = 1; cyc("R6 hit cpu");
        check("R6 miss sel with hit", 32'(exp_hit[0]), 0);
        bus_dma = 1; set_bus(0, 0, 0, 2, 1); cyc("R6 dma");
        check("R6 dma", 32'(exp_hit[0]), 1);
        bus_dma = 0; bus_cache_hit = 0;

        // R9: pass counter of 3 fires on third match only, then silent
        wr(0, 3, 32'd3); wr(0, 0, 32'h0000_0081);
        wr(0, 1, 32'h55);
        for (int i = 0; i < 5; i++) begin
            set_bus(32'h55, 0, 0, 2, 1); cyc("R9 count");
            check("R9 count pulse", 32'(exp_hit[0]), (i == 2) ? 1 : 0);
        end
        wr(0, 3, 32'd0);
        set_bus(32'h55, 0, 0, 2, 1); cyc("R9 zero");
        check("R9 zero count", 32'(exp_hit[0]), 0);

        // R10: data enable on channel 2 dropped; R11 step mute
        wr(1, 1, 32'h77); wr(1, 2, 32'hFFFF_FFFF); wr(1, 0, 32'h0000_0005);
        set_bus(32'h77, 0, 32'h0, 2, 1); cyc("R10 cap");
        check("R10 data dropped ch2", 32'(exp_hit[1]), 1);
        step_mode = 1; set_bus(32'h77, 0, 32'h0, 2, 1); cyc("R11 step");
        check("R11 step mute", 32'(exp_hit[1]), 0);
        step_mode = 0;

        // R13: channel code 3 writes nothing
        wr(3, 1, 32'h0); wr(3, 0, 32'h0);
        set_bus(32'h77, 0, 32'h0, 2, 1); cyc("R13 chan3 code");
        check("R13 unused chan code", 32'(exp_hit[1]), 1);

        // Random phase
        for (int blk = 0; blk < 60; blk++) begin
            for (int ch = 0; ch < 4; ch++) begin
                wr(ch, 1, $urandom & 32'hFF);
                wr(ch, 2, $urandom);
                wr(ch, 3, $urandom % 4);
                wr(ch, 0, $urandom & 32'hFFF & ~32'h040);
            end
            for (int i = 0; i < 40; i++) begin
                int sel;
                sel = $urandom % 3;
                set_bus(($urandom % 2) ? addr_m[sel] : ($urandom & 32'hFF),
                        ($urandom % 2) ? addr_m[sel] : ($urandom & 32'hFF),
                        ($urandom % 2) ? data_m[sel] : $urandom,
                        ($urandom % 2) ? ctrl_m[sel][11:10] : 2'($urandom),
                        1'($urandom));
                bus_valid = ($urandom % 8) != 0;
                bus_fetch = 1'($urandom); bus_cache_hit = 1'($urandom);
                bus_dma = 1'($urandom); bus_io = 1'($urandom);
                step_mode = ($urandom % 4) == 0;
                cyc("R3 R4 R5 R6 R8 R9 R11 random");
            end
            step_mode = 0;
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule